// File: doc/BRIEF.md
# Triple-Ones Run Detector

This block watches a one-bit serial input, sampled once per clock, and raises a one-bit detect output whenever the input has carried three logic 1s on consecutive clocks. Detection is non-overlapping. Once a triple is reported, the run count starts again from zero, so the 1s that complete one match are never reused for the next. A run of six 1s therefore gives two detections, and a run of five gives one.

An elaboration-time parameter chooses between two output forms. In the Mealy form, the detect output is a combinational function of the state and the input. It rises in the same cycle that the third 1 is presented. In the Moore form, the output is decoded from the registered state alone. It rises one clock later and carries no combinational path from the input. Both forms use a fixed two-bit state code. In the Mealy form, the spare code is handled explicitly so that the machine always recovers from it.

Top module: `trio_run_detector`

## Requirements
- R1: A synchronous active-high reset forces the state code to 00. The detect output is 0 in every cycle in which reset is high, and in the first cycle after reset is released.
- R2: In the Mealy form, the detect output is 1 in the same cycle as the third consecutive 1 on the input, and it is 0 in every other cycle.
- R3: Detection is non-overlapping. After a detection the run count restarts at zero, so six consecutive 1s give exactly two detections and five give exactly one. The detect output is never 1 on two consecutive clocks.
- R4: A 0 on the input returns the state to code 00 at the next clock from any state. Two 1s, a 0 and then a single 1 give no detection.
- R5: The Moore form produces the same detect stream as the Mealy form, delayed by exactly one clock. Its state codes are 00, 01 and 10 for zero, one and two new 1s, and 11 for three. A 1 in state 11 moves it to 01.
- R6: In the Mealy form, the input stream 01101111011111001111110 (leftmost bit first, one bit per clock) produces the detect stream 00000010000100000010010, cycle for cycle.
- R7: On long pseudo-random input streams, both forms match a behavioural run-length model on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit, sampled each clock |
| hit | output | 1 | Detect pulse, one cycle per reported triple |

## Verification
The bound checker tests several rules on every clock. Reset and the first clock after it keep the detect output quiet. A 0 always sends the state to 00. A detect pulse is never followed by another on the next clock. A detect is always preceded by the correct number of 1s. In the Moore form, a 1 in state 11 lands in state 01. In the Mealy form, the spare code 11 is never occupied. Only the bench scenarios can show the exact pulse positions: the six-ones and five-ones counts, the full example stream bit for bit, the one-clock lag between the two forms, and agreement with the run-length model over random streams.

// File: rtl/trio_pkg.sv
package trio_pkg;

   // Width of the state code; fixed by the two-bit encoding.
   localparam int STATE_W = 2;

   typedef logic [STATE_W-1:0] trio_state_t;

   // State codes: count of new 1s seen in the current run.
   localparam trio_state_t ST_NONE  = 2'b00;
   localparam trio_state_t ST_ONE   = 2'b01;
   localparam trio_state_t ST_TWO   = 2'b10;
   localparam trio_state_t ST_THREE = 2'b11;   // Moore only; spare in Mealy

   typedef enum logic {
      FORM_MEALY = 1'b0,
      FORM_MOORE = 1'b1
   } detect_form_e;

endpackage

// File: rtl/trio_next_state.sv
module trio_next_state
   import trio_pkg::*;
#(
   parameter detect_form_e FORM = FORM_MEALY
)(
   input  trio_state_t cur,
   input  logic        din,
   output trio_state_t nxt
);

   generate
      if (FORM == FORM_MOORE) begin : g_moore
         // Sum-of-products form: N1 = X(P1^P0), N0 = X(~P0 | P1)
         always_comb begin
            nxt[1] = din & (cur[1] ^ cur[0]);
            nxt[0] = din & (~cur[0] | cur[1]);
         end
      end else begin : g_mealy
         always_comb begin
            nxt = ST_NONE;
            if (din) begin
               unique case (cur)
                  ST_NONE:  nxt = ST_ONE;
                  ST_ONE:   nxt = ST_TWO;
                  ST_TWO:   nxt = ST_NONE;   // third 1: report and restart
                  default:  nxt = ST_NONE;   // spare code recovers
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/trio_state_reg.sv
module trio_state_reg
   import trio_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  trio_state_t nxt,
   output trio_state_t cur
);

   always_ff @(posedge clk) begin
      if (rst) cur <= ST_NONE;
      else     cur <= nxt;
   end

endmodule

// File: rtl/trio_out_decode.sv
module trio_out_decode
   import trio_pkg::*;
#(
   parameter detect_form_e FORM = FORM_MEALY
)(
   input  logic        rst,
   input  trio_state_t cur,
   input  logic        din,
   output logic        hit
);

   generate
      if (FORM == FORM_MOORE) begin : g_moore
         // Depends on the present state only.
         assign hit = ~rst & cur[1] & cur[0];
      end else begin : g_mealy
         // Third 1 arriving while two are already counted.
         assign hit = ~rst & din & (cur == ST_TWO);
      end
   endgenerate

endmodule

// File: rtl/trio_run_detector.sv
module trio_run_detector
   import trio_pkg::*;
#(
   parameter detect_form_e FORM = FORM_MEALY
)(
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic hit
);

   trio_state_t cur_state;
   trio_state_t nxt_state;

   trio_next_state #(.FORM(FORM)) u_next (
      .cur (cur_state),
      .din (din),
      .nxt (nxt_state)
   );

   trio_state_reg u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_state),
      .cur (cur_state)
   );

   trio_out_decode #(.FORM(FORM)) u_dec (
      .rst (rst),
      .cur (cur_state),
      .din (din),
      .hit (hit)
   );

endmodule

// File: rtl/trio_run_detector_chk.sv
module trio_run_detector_chk
   import trio_pkg::*;
#(
   parameter detect_form_e FORM = FORM_MEALY
)(
   input  logic        clk,
   input  logic        rst,
   input  logic        din,
   input  logic        hit,
   input  trio_state_t state
);

   initial begin
      if (STATE_W != 2) $error("trio_run_detector: state code must be two bits");
   end

   AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !hit); // R1
   AST_POST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !hit); // R1
   AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst) !din |=> state == ST_NONE); // R4
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst) hit |=> !hit); // R3

   generate
      if (FORM == FORM_MOORE) begin : g_moore
         AST_MOORE_RESTART: assert property (@(posedge clk) disable iff (rst)
            (state == ST_THREE && din) |=> state == ST_ONE); // R5
         AST_MOORE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
            hit |-> ($past(din) && $past(din, 2) && $past(din, 3))); // R5
      end else begin : g_mealy
         AST_MEALY_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
            hit |-> (din && $past(din) && $past(din, 2))); // R2
         AST_MEALY_SPARE_UNUSED: assert property (@(posedge clk) disable iff (rst)
            state != ST_THREE); // R1
      end
   endgenerate

endmodule

bind trio_run_detector trio_run_detector_chk #(.FORM(FORM)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .din   (din),
   .hit   (hit),
   .state (cur_state)
);

// File: tb/trio_run_detector_tb.sv
module trio_run_detector_tb;
   import trio_pkg::*;

   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic hit_mealy;
   logic hit_moore;

   int n_checks = 0;
   int n_bad    = 0;

   // behavioural model state
   int   run_cnt   = 0;
   logic prev_mealy = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trio_run_detector #(.FORM(FORM_MEALY)) u_dut (
      .clk (clk), .rst (rst), .din (din), .hit (hit_mealy)
   );

   trio_run_detector #(.FORM(FORM_MOORE)) u_dut_moore (
      .clk (clk), .rst (rst), .din (din), .hit (hit_moore)
   );

   task automatic check(input logic act, input logic exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, sample just after, update model.
   task automatic step(input logic b, input logic r, input string tag,
                       output logic exp_m);
      logic exp_o;
      @(negedge clk);
      din = b;
      rst = r;
      #1;
      exp_m = !r && b && (run_cnt == 2);
      exp_o = !r && prev_mealy;
      check(hit_mealy, exp_m, {tag, " mealy"});
      check(hit_moore, exp_o, {tag, " moore R5"});
      if (r || !b)            run_cnt = 0;
      else if (run_cnt == 2)  run_cnt = 0;
      else                    run_cnt = run_cnt + 1;
      prev_mealy = exp_m;
   endtask

   task automatic do_reset();
      logic e;
      step(1'b0, 1'b1, "R1 reset", e);
      step(1'b0, 1'b0, "R1 after reset", e);
   endtask

   task automatic t_reset();
      logic e;
      // Build up two 1s, then assert reset while a third 1 is present.
      step(1'b1, 1'b0, "R1 pre", e);
      step(1'b1, 1'b0, "R1 pre", e);
      step(1'b1, 1'b1, "R1 reset with third one", e);
      check(hit_mealy, 1'b0, "R1 mealy quiet in reset");
      step(1'b1, 1'b0, "R1 first cycle after reset", e);
      check(hit_moore, 1'b0, "R1 moore quiet after reset");
      step(1'b0, 1'b0, "R1 idle", e);
   endtask

   task automatic t_three();
      logic e;
      step(1'b1, 1'b0, "R2 first", e);
      step(1'b1, 1'b0, "R2 second", e);
      step(1'b1, 1'b0, "R2 third", e);
      check(hit_mealy, 1'b1, "R2 same-cycle detect");
      step(1'b0, 1'b0, "R2 after", e);
      check(hit_moore, 1'b1, "R5 moore one clock later");
      step(1'b0, 1'b0, "R2 idle", e);
   endtask

   task automatic t_runs();
      logic e;
      int hits;
      hits = 0;
      for (int i = 0; i < 6; i++) begin
         step(1'b1, 1'b0, "R3 six ones", e);
         hits += int'(hit_mealy);
      end
      step(1'b0, 1'b0, "R3 gap", e);
      check(hits == 2, 1'b1, "R3 six ones give two detects");
      step(1'b0, 1'b0, "R3 gap", e);
      hits = 0;
      for (int i = 0; i < 5; i++) begin
         step(1'b1, 1'b0, "R3 five ones", e);
         hits += int'(hit_mealy);
      end
      step(1'b0, 1'b0, "R3 gap", e);
      check(hits == 1, 1'b1, "R3 five ones give one detect");
      step(1'b0, 1'b0, "R3 gap", e);
   endtask

   task automatic t_zero_break();
      logic e;
      step(1'b1, 1'b0, "R4 one", e);
      step(1'b1, 1'b0, "R4 two", e);
      step(1'b0, 1'b0, "R4 break", e);
      step(1'b1, 1'b0, "R4 single one after break", e);
      check(hit_mealy, 1'b0, "R4 no detect after break");
      step(1'b0, 1'b0, "R4 idle", e);
      check(hit_moore, 1'b0, "R4 moore no detect after break");
      step(1'b0, 1'b0, "R4 idle", e);
   endtask

   task automatic t_example();
      localparam int N = 23;
      logic [N-1:0] stim = 23'b01101111011111001111110;
      logic [N-1:0] want = 23'b00000010000100000010010;
      logic e;
      do_reset();
      for (int i = N-1; i >= 0; i--) begin
         step(stim[i], 1'b0, "R6 example", e);
         check(hit_mealy, want[i], "R6 example stream bit");
      end
      step(1'b0, 1'b0, "R6 tail", e);
   endtask

   task automatic t_random();
      logic [15:0] lfsr = 16'hACE1;
      logic e;
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[1:0] != 2'b00, 1'b0, "R7 random stream", e);
      end
      for (int i = 0; i < 200; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], (lfsr[7:3] == 5'd0), "R7 random with resets", e);
      end
   endtask

   initial begin
      #1;
      check(hit_mealy, 1'b0, "R1 mealy at reset");
      check(hit_moore, 1'b0, "R1 moore at reset");
      do_reset();
      t_reset();
      t_three();
      t_runs();
      t_zero_break();
      t_example();
      t_random();
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule